// File: doc/BRIEF.md
# One-of-Four Return-to-Zero Channel Codec

This block converts between plain binary words and a delay-insensitive, return-to-zero channel in which every pair of bits travels on four wires. Exactly one of those four wires is high for each pair. The transmit half encodes a word into one-hot symbols and drives it onto the channel. After the codeword has been acknowledged, it drops every wire to zero (the spacer) before it accepts another word. The receive half watches the incoming wires. It reports whether every symbol is complete, whether the whole channel has fallen back to the spacer, and whether any symbol carries more than one active wire. It acknowledges complete codewords through a four-phase handshake: codeword, completion, acknowledge, spacer, reset seen, release.

Two helpers work directly on the received coded wires, with no prior decode. The first pulls out any single bit of the word, and reports whether the symbol holding it has arrived. The second produces the one-place left shift of the word, already in one-hot form. This shift needs real logic, because every output symbol takes one bit from each of two neighbouring input symbols.

Transmit states: TX_SPACE drives the spacer and accepts a word. TX_CODE drives the codeword until acknowledge. TX_RTZ drives the spacer until acknowledge falls. Transitions: TX_SPACE→TX_CODE on `tx_valid`; TX_CODE→TX_RTZ on `tx_ack`; TX_RTZ→TX_SPACE on `!tx_ack`. Receive states: RX_WAIT (acknowledge low) and RX_HOLD (acknowledge high). Transitions: RX_WAIT→RX_HOLD when the word is complete; RX_HOLD→RX_WAIT when the channel is all low.

Top module: `quad_wire_codec`

## Requirements
- R1: Symbol k of `tx_wires` (bits 4k+3..4k) carries bits 2k+1..2k of the word. Pair value 0, 1, 2 and 3 drives wire 0, 1, 2 and 3 of the symbol, giving 0001, 0010, 0100 and 1000.
- R2: After reset, and in TX_SPACE, `tx_wires` is all zero and `tx_ready` is 1. A word accepted on a clock edge appears on `tx_wires` after that edge. It stays there until an edge sees `tx_ack` high, after which the wires are all zero. They stay zero, with `tx_ready` low, until an edge sees `tx_ack` low; `tx_ready` is then 1 again.
- R3: `tx_valid` and `tx_data` have no effect outside TX_SPACE. A word presented while a codeword is being driven leaves `tx_wires` unchanged.
- R4: `rx_done` is 1 exactly when every symbol of `rx_wires` has exactly one high wire. A word with any all-low symbol gives `rx_done` 0.
- R5: `rx_empty` is 1 exactly when all wires of `rx_wires` are low.
- R6: `rx_err` is 1 when any symbol has two or more high wires. Such a word is never acknowledged.
- R7: In RX_WAIT, an edge that sees `rx_done` raises `rx_ack`, loads the decoded word into `rx_data` and pulses `rx_strobe` for one cycle. `rx_ack` stays high until an edge sees `rx_empty`, and falls after that edge.
- R8: `ext_bit` is bit `ext_idx` of the received word, read from symbol `ext_idx/2`. An odd index is the upper bit of the pair, set by wire 2 or 3. An even index is the lower bit, set by wire 1 or 3. `ext_known` is 1 when that symbol has any high wire; other symbols do not matter.
- R9: `sh_wires` is the one-hot encoding of (word << 1) | `sh_in`, truncated to the word width. An output symbol k is all zero when input symbol k, or symbol k−1 (for k > 0), is all zero. An all-zero input therefore gives an all-zero output.
- R10: Reset (synchronous, active high) puts both sequencers in their idle states: `rx_ack` 0, `rx_strobe` 0 and `rx_data` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Word offered for transmission |
| tx_data | input | 2*NSYM | Word to transmit |
| tx_ready | output | 1 | Transmitter idle in spacer, will accept a word |
| tx_wires | output | 4*NSYM | Coded transmit channel |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_wires | input | 4*NSYM | Coded receive channel |
| rx_done | output | 1 | Every symbol complete |
| rx_empty | output | 1 | All wires low (spacer) |
| rx_err | output | 1 | Some symbol has several high wires |
| rx_ack | output | 1 | Acknowledge to the far transmitter |
| rx_strobe | output | 1 | One-cycle pulse when a word is captured |
| rx_data | output | 2*NSYM | Last captured word |
| ext_idx | input | $clog2(2*NSYM) | Bit index for extraction |
| ext_bit | output | 1 | Extracted bit |
| ext_known | output | 1 | Symbol holding the extracted bit has arrived |
| sh_in | input | 1 | Bit shifted into position 0 |
| sh_wires | output | 4*NSYM | Coded left-shifted word |

## Verification
If a sequencer state were wrong, the channel would show it within one clock. `tx_wires` would carry a codeword while `tx_ready` is high, or it would change from one codeword to another with no spacer between them. Likewise `rx_ack` would rise without a complete word or fall without a spacer. A wrong detector or coded-domain path shows up at once and without any clock, as a done, empty or error flag that disagrees with the wire count, or as a shifted or extracted value that differs from the binary reference.

// File: rtl/quad_wire_pkg.sv
package quad_wire_pkg;

    typedef enum logic [1:0] {
        TX_SPACE = 2'd0,
        TX_CODE  = 2'd1,
        TX_RTZ   = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_HOLD = 1'b1
    } rx_state_t;

    // binary pair -> one-hot symbol
    function automatic logic [3:0] pair_to_wires(input logic [1:0] p);
        return 4'b0001 << p;
    endfunction

    // one-hot symbol -> binary pair (upper: wire 2 or 3, lower: wire 1 or 3)
    function automatic logic [1:0] wires_to_pair(input logic [3:0] w);
        return {w[3] | w[2], w[3] | w[1]};
    endfunction

    // two or more wires high
    function automatic logic sym_multi(input logic [3:0] w);
        return (w[0] & w[1]) | (w[0] & w[2]) | (w[0] & w[3]) |
               (w[1] & w[2]) | (w[1] & w[3]) | (w[2] & w[3]);
    endfunction

endpackage

// File: rtl/qw_word_encode.sv
module qw_word_encode
    import quad_wire_pkg::*;
#(
    parameter int NSYM = 4
) (
    input  logic [2*NSYM-1:0] data,
    output logic [4*NSYM-1:0] wires
);
    for (genvar k = 0; k < NSYM; k++) begin : g_lane
        assign wires[4*k +: 4] = pair_to_wires(data[2*k +: 2]);
    end
endmodule

// File: rtl/qw_word_detect.sv
module qw_word_detect
    import quad_wire_pkg::*;
#(
    parameter int NSYM = 4
) (
    input  logic [4*NSYM-1:0] wires,
    output logic              done,
    output logic              empty,
    output logic              err,
    output logic [2*NSYM-1:0] data
);
    logic [NSYM-1:0] sym_any;
    logic [NSYM-1:0] sym_multi_v;

    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        assign sym_any[k]      = |wires[4*k +: 4];
        assign sym_multi_v[k]  = sym_multi(wires[4*k +: 4]);
        assign data[2*k +: 2]  = wires_to_pair(wires[4*k +: 4]);
    end

    // word completion: AND of per-symbol OR, with no symbol overfull
    assign done  = (&sym_any) & ~(|sym_multi_v);
    assign empty = ~(|wires);
    assign err   = |sym_multi_v;
endmodule

// File: rtl/qw_tx_seq.sv
module qw_tx_seq
    import quad_wire_pkg::*;
#(
    parameter int NSYM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic              tx_ack,
    input  logic [4*NSYM-1:0] code_in,
    output logic              tx_ready,
    output logic [4*NSYM-1:0] tx_wires
);
    tx_state_t         state_q, state_d;
    logic [4*NSYM-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_SPACE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_SPACE && tx_valid) code_q <= code_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_SPACE: if (tx_valid) state_d = TX_CODE;
            TX_CODE:  if (tx_ack)   state_d = TX_RTZ;
            TX_RTZ:   if (!tx_ack)  state_d = TX_SPACE;
            default:                state_d = TX_SPACE;
        endcase
    end

    always_comb begin
        tx_ready = 1'b0;
        tx_wires = '0;
        unique case (state_q)
            TX_SPACE: tx_ready = 1'b1;
            TX_CODE:  tx_wires = code_q;
            TX_RTZ:   tx_wires = '0;
            default:  tx_wires = '0;
        endcase
    end
endmodule

// File: rtl/qw_rx_seq.sv
module qw_rx_seq
    import quad_wire_pkg::*;
#(
    parameter int NSYM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              empty,
    input  logic [2*NSYM-1:0] data_in,
    output logic              rx_ack,
    output logic              rx_strobe,
    output logic [2*NSYM-1:0] rx_data
);
    rx_state_t         state_q, state_d;
    logic [2*NSYM-1:0] data_q;
    logic              strobe_q;
    logic              capture;

    assign capture = (state_q == RX_WAIT) && done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_WAIT;
            data_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= capture;
            if (capture) data_q <= data_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_WAIT: if (done)  state_d = RX_HOLD;
            RX_HOLD: if (empty) state_d = RX_WAIT;
            default:            state_d = RX_WAIT;
        endcase
    end

    always_comb begin
        rx_ack    = 1'b0;
        rx_strobe = strobe_q;
        rx_data   = data_q;
        unique case (state_q)
            RX_WAIT: rx_ack = 1'b0;
            RX_HOLD: rx_ack = 1'b1;
            default: rx_ack = 1'b0;
        endcase
    end
endmodule

// File: rtl/qw_coded_ops.sv
module qw_coded_ops #(
    parameter int NSYM = 4,
    localparam int IW  = $clog2(2*NSYM)
) (
    input  logic [4*NSYM-1:0] wires,
    input  logic              sh_in,
    input  logic [IW-1:0]     ext_idx,
    output logic [4*NSYM-1:0] sh_wires,
    output logic              ext_bit,
    output logic              ext_known
);
    // per-symbol rails for each bit of the pair
    logic [NSYM-1:0] hi_set, hi_clr, lo_set, lo_clr;

    for (genvar k = 0; k < NSYM; k++) begin : g_rail
        assign hi_set[k] = wires[4*k+3] | wires[4*k+2];
        assign hi_clr[k] = wires[4*k+1] | wires[4*k+0];
        assign lo_set[k] = wires[4*k+3] | wires[4*k+1];
        assign lo_clr[k] = wires[4*k+2] | wires[4*k+0];
    end

    // shifted symbol k: upper <- lower bit of k, lower <- upper bit of k-1
    for (genvar k = 0; k < NSYM; k++) begin : g_shift
        logic in_set, in_clr;
        if (k == 0) begin : g_first
            assign in_set = sh_in;
            assign in_clr = ~sh_in;
        end else begin : g_rest
            assign in_set = hi_set[k-1];
            assign in_clr = hi_clr[k-1];
        end
        assign sh_wires[4*k+0] = lo_clr[k] & in_clr;
        assign sh_wires[4*k+1] = lo_clr[k] & in_set;
        assign sh_wires[4*k+2] = lo_set[k] & in_clr;
        assign sh_wires[4*k+3] = lo_set[k] & in_set;
    end

    // single-bit extraction
    logic [IW-2:0] sym_sel;
    logic [3:0]    sym_w;
    assign sym_sel   = ext_idx[IW-1:1];
    assign sym_w     = wires[4*sym_sel +: 4];
    assign ext_bit   = ext_idx[0] ? (sym_w[3] | sym_w[2]) : (sym_w[3] | sym_w[1]);
    assign ext_known = |sym_w;
endmodule

// File: rtl/quad_wire_codec.sv
module quad_wire_codec #(
    parameter int NSYM = 4,
    localparam int DW  = 2*NSYM,
    localparam int CW  = 4*NSYM,
    localparam int IW  = $clog2(2*NSYM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic [CW-1:0] tx_wires,
    input  logic          tx_ack,
    input  logic [CW-1:0] rx_wires,
    output logic          rx_done,
    output logic          rx_empty,
    output logic          rx_err,
    output logic          rx_ack,
    output logic          rx_strobe,
    output logic [DW-1:0] rx_data,
    input  logic [IW-1:0] ext_idx,
    output logic          ext_bit,
    output logic          ext_known,
    input  logic          sh_in,
    output logic [CW-1:0] sh_wires
);
    logic [CW-1:0] enc_code;
    logic [DW-1:0] dec_word;

    qw_word_encode #(.NSYM(NSYM)) u_enc (
        .data  (tx_data),
        .wires (enc_code)
    );

    qw_tx_seq #(.NSYM(NSYM)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .tx_ack   (tx_ack),
        .code_in  (enc_code),
        .tx_ready (tx_ready),
        .tx_wires (tx_wires)
    );

    qw_word_detect #(.NSYM(NSYM)) u_det (
        .wires (rx_wires),
        .done  (rx_done),
        .empty (rx_empty),
        .err   (rx_err),
        .data  (dec_word)
    );

    qw_rx_seq #(.NSYM(NSYM)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .done      (rx_done),
        .empty     (rx_empty),
        .data_in   (dec_word),
        .rx_ack    (rx_ack),
        .rx_strobe (rx_strobe),
        .rx_data   (rx_data)
    );

    qw_coded_ops #(.NSYM(NSYM)) u_ops (
        .wires     (rx_wires),
        .sh_in     (sh_in),
        .ext_idx   (ext_idx),
        .sh_wires  (sh_wires),
        .ext_bit   (ext_bit),
        .ext_known (ext_known)
    );
endmodule

// File: rtl/quad_wire_codec_chk.sv
module quad_wire_codec_chk #(
    parameter int NSYM = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [4*NSYM-1:0] tx_wires,
    input logic            tx_ready,
    input logic            tx_ack,
    input logic [4*NSYM-1:0] rx_wires,
    input logic            rx_done,
    input logic            rx_empty,
    input logic            rx_err,
    input logic            rx_ack,
    input logic            rx_strobe
);
    for (genvar k = 0; k < NSYM; k++) begin : g_sym
        AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(tx_wires[4*k +: 4])); // R1
    end

    AST_TX_READY_SPACER: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (tx_wires == '0)); // R2

    AST_TX_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        ((tx_wires != '0) && ($past(tx_wires) != '0)) |-> (tx_wires == $past(tx_wires))); // R2

    AST_TX_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        ((tx_wires != '0) && !tx_ack) |=> (tx_wires == $past(tx_wires))); // R3

    AST_RX_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> ($countones(rx_wires) == NSYM)); // R4

    AST_RX_EMPTY_COUNT: assert property (@(posedge clk) disable iff (rst)
        rx_empty |-> ($countones(rx_wires) == 0)); // R5

    AST_RX_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (!rx_done && ($countones(rx_wires) > 1))); // R6

    AST_RX_ACK_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ack) |-> $past(rx_done)); // R7

    AST_RX_ACK_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ack) |-> $past(rx_empty)); // R7

    AST_RX_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe); // R7
endmodule

bind quad_wire_codec quad_wire_codec_chk #(.NSYM(NSYM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_wires  (tx_wires),
    .tx_ready  (tx_ready),
    .tx_ack    (tx_ack),
    .rx_wires  (rx_wires),
    .rx_done   (rx_done),
    .rx_empty  (rx_empty),
    .rx_err    (rx_err),
    .rx_ack    (rx_ack),
    .rx_strobe (rx_strobe)
);

// File: tb/quad_wire_codec_test.sv
`timescale 1ns/1ps
module quad_wire_codec_test;
    localparam int NS = 4;
    localparam int DW = 2*NS;
    localparam int CW = 4*NS;
    localparam int IW = $clog2(2*NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          tx_ready;
    logic [CW-1:0] tx_wires;
    logic          tx_ack = 1'b0;
    logic [CW-1:0] rx_wires = '0;
    logic          rx_done, rx_empty, rx_err, rx_ack, rx_strobe;
    logic [DW-1:0] rx_data;
    logic [IW-1:0] ext_idx = '0;
    logic          ext_bit, ext_known;
    logic          sh_in = 1'b0;
    logic [CW-1:0] sh_wires;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    quad_wire_codec #(.NSYM(NS)) uut (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_wires(tx_wires), .tx_ack(tx_ack),
        .rx_wires(rx_wires), .rx_done(rx_done), .rx_empty(rx_empty),
        .rx_err(rx_err), .rx_ack(rx_ack), .rx_strobe(rx_strobe),
        .rx_data(rx_data), .ext_idx(ext_idx), .ext_bit(ext_bit),
        .ext_known(ext_known), .sh_in(sh_in), .sh_wires(sh_wires)
    );

    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CW-1:0] r = '0;
        for (int k = 0; k < NS; k++) begin
            case ({d[2*k+1], d[2*k]})
                2'b00: r[4*k +: 4] = 4'b0001;
                2'b01: r[4*k +: 4] = 4'b0010;
                2'b10: r[4*k +: 4] = 4'b0100;
                default: r[4*k +: 4] = 4'b1000;
            endcase
        end
        return r;
    endfunction

    function automatic logic [CW-1:0] ref_shift(input logic [DW-1:0] d, input logic si,
                                                input logic [NS-1:0] present);
        logic [DW-1:0] s = {d[DW-2:0], si};
        logic [CW-1:0] r = ref_enc(s);
        for (int k = 0; k < NS; k++) begin
            if (!present[k] || (k > 0 && !present[k-1])) r[4*k +: 4] = 4'b0000;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one full transmit handshake for word d
    task automatic tx_word(input logic [DW-1:0] d, input bit poke);
        tx_data  = d;
        tx_valid = 1'b1;
        tick();
        tx_valid = 1'b0;
        check(tx_wires == ref_enc(d), "R1 encode", tx_wires, ref_enc(d));
        check(tx_ready == 1'b0, "R2 busy after accept", tx_ready, 0);
        if (poke) begin
            tx_data  = ~d;
            tx_valid = 1'b1;
            tick();
            tick();
            tx_valid = 1'b0;
            check(tx_wires == ref_enc(d), "R3 new word ignored while driving", tx_wires, ref_enc(d));
        end
        tx_ack = 1'b1;
        tick();
        check(tx_wires == '0, "R2 spacer after ack", tx_wires, 0);
        tick();
        check(tx_wires == '0 && !tx_ready, "R2 spacer held while ack high", {tx_ready, tx_wires}, 0);
        tx_ack = 1'b0;
        tick();
        check(tx_ready == 1'b1 && tx_wires == '0, "R2 ready after ack low", {tx_ready, tx_wires}, {1'b1, {CW{1'b0}}});
    endtask

    // one full receive handshake for word d
    task automatic rx_word(input logic [DW-1:0] d);
        rx_wires = ref_enc(d);
        #1;
        check(rx_done && !rx_empty && !rx_err, "R4 done on full word", {rx_done, rx_empty, rx_err}, 3'b100);
        tick();
        check(rx_ack && rx_strobe, "R7 ack and strobe", {rx_ack, rx_strobe}, 2'b11);
        check(rx_data == d, "R7 captured data", rx_data, d);
        tick();
        check(rx_ack && !rx_strobe, "R7 strobe single, ack held", {rx_ack, rx_strobe}, 2'b10);
        rx_wires = '0;
        #1;
        check(rx_empty && !rx_done, "R5 empty on spacer", {rx_empty, rx_done}, 2'b10);
        tick();
        check(!rx_ack, "R7 ack released after spacer", rx_ack, 0);
    endtask

    initial begin
        logic [DW-1:0] d;
        logic [CW-1:0] w;
        void'($urandom(32'd20240611));
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R10 / R2 reset state
        check(tx_wires == '0 && tx_ready, "R2 reset spacer", {tx_ready, tx_wires}, {1'b1, {CW{1'b0}}});
        check(!rx_ack && !rx_strobe && rx_data == '0, "R10 reset rx idle", {rx_ack, rx_strobe, rx_data}, 0);

        // transmit: directed then random
        tx_word('0, 1'b1);
        tx_word({DW{1'b1}}, 1'b0);
        tx_word(8'h1B, 1'b1);
        for (int i = 0; i < 20; i++) tx_word(DW'($urandom), i[0]);

        // receive: directed then random
        rx_word(8'h1B);
        rx_word('0);
        for (int i = 0; i < 20; i++) rx_word(DW'($urandom));

        // incomplete word: one symbol missing
        for (int i = 0; i < NS; i++) begin
            w = ref_enc(DW'($urandom));
            w[4*i +: 4] = 4'b0000;
            rx_wires = w;
            #1;
            check(!rx_done && !rx_empty && !rx_err, "R4 partial word not done", {rx_done, rx_empty, rx_err}, 0);
            tick();
            check(!rx_ack, "R4 partial word not acknowledged", rx_ack, 0);
        end

        // overfull symbol
        for (int i = 0; i < NS; i++) begin
            w = ref_enc(DW'($urandom));
            w[4*i +: 4] = w[4*i +: 4] | 4'b0101;
            if (w[4*i +: 4] == 4'b0101) w[4*i +: 4] = 4'b0111;
            rx_wires = w;
            #1;
            check(rx_err && !rx_done, "R6 overfull flagged", {rx_err, rx_done}, 2'b10);
            tick();
            check(!rx_ack, "R6 overfull not acknowledged", rx_ack, 0);
        end
        rx_wires = '0;
        tick();

        // extraction
        for (int i = 0; i < 40; i++) begin
            logic [IW-1:0] idx;
            int            gone;
            d    = DW'($urandom);
            idx  = IW'($urandom);
            w    = ref_enc(d);
            gone = $urandom_range(0, NS);
            if (gone < NS) w[4*gone +: 4] = 4'b0000;
            rx_wires = w;
            ext_idx  = idx;
            #1;
            if (gone == int'(idx >> 1))
                check(!ext_known, "R8 missing symbol unknown", ext_known, 0);
            else
                check(ext_known && ext_bit == d[idx], "R8 extract bit",
                      {ext_known, ext_bit}, {1'b1, d[idx]});
            tick();
        end

        // coded-domain shift
        for (int i = 0; i < 40; i++) begin
            logic [NS-1:0] pres;
            d    = (i == 0) ? {DW{1'b1}} : DW'($urandom);
            pres = (i < 25) ? {NS{1'b1}} : NS'($urandom);
            w    = ref_enc(d);
            for (int k = 0; k < NS; k++) if (!pres[k]) w[4*k +: 4] = 4'b0000;
            rx_wires = w;
            sh_in    = (i == 1) ? 1'b1 : 1'($urandom);
            #1;
            check(sh_wires == ref_shift(d, sh_in, pres), "R9 coded shift",
                  sh_wires, ref_shift(d, sh_in, pres));
            tick();
        end
        rx_wires = '0;
        sh_in    = 1'b1;
        #1;
        check(sh_wires == '0, "R9 spacer shifts to spacer", sh_wires, 0);
        tick();

        // loopback of transmitter into receiver
        for (int i = 0; i < 6; i++) begin
            d = DW'($urandom);
            tx_data  = d;
            tx_valid = 1'b1;
            tick();
            tx_valid = 1'b0;
            rx_wires = tx_wires;
            tick();
            check(rx_ack && rx_data == d, "R7 loopback capture", rx_data, d);
            tx_ack = rx_ack;
            tick();
            rx_wires = tx_wires;
            tick();
            check(!rx_ack, "R2 loopback spacer releases ack", rx_ack, 0);
            tx_ack = rx_ack;
            tick();
            check(tx_ready, "R2 loopback ready", tx_ready, 1);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule